// File: doc/BRIEF.md
# Strobed Output Port Expander

This block turns one shared byte-wide bus and two control strobes into a bank of byte-wide output ports. A host first puts a port number on the bus and pulses the address strobe. The number is captured while the strobe is high and stays fixed once the strobe drops. The host then raises the data strobe. From that point the chosen port copies the bus on every cycle, so a run of writes to the same port needs no further addressing. Every port that is not selected holds its contents.

Both strobes and the bus come from outside the clock domain. They pass through two-flop synchronizers before any decision is taken. The port registers therefore show a bus value three clock edges after it is sampled. Raising both strobes at once is a protocol fault: the address is still captured, no port is written, and a sticky error flag is set that only reset clears.

Top module: `latched_port_expander`

## Requirements
- R1: After reset every port output is 0 and `protoErr` is 0; both strobes are treated as low.
- R2: While `addrLe` is high the port number is taken from the bus; once `addrLe` falls the number is frozen, and later bus changes with `addrLe` low do not alter which port is selected.
- R3: Port number k (0 to NUM_PORTS-1) selects the output byte `portsOut[k*8 +: 8]`.
- R4: While `dataLe` is high and `addrLe` is low, the selected port follows the bus. A bus value sampled at clock edge E appears on the port after edge E+2.
- R5: While `dataLe` is low, no port output changes, whatever the bus does.
- R6: Ports other than the selected one never change, and at most one port changes in any cycle.
- R7: When `addrLe` and `dataLe` are high together, no port is written, the bus value is still captured as the port number, and `protoErr` goes to 1 and stays 1 until reset.
- R8: Only bus bits [2:0] form the port number; bits [7:3] are ignored during addressing.
- R9: A port number of NUM_PORTS or more (6 or 7 with the default of 6 ports) writes no port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busIn | input | BUS_W | Shared address/data bus |
| addrLe | input | 1 | Address strobe; high captures the port number |
| dataLe | input | 1 | Data strobe; high makes the selected port follow the bus |
| portsOut | output | NUM_PORTS*BUS_W | All port outputs, port k at bits [k*BUS_W +: BUS_W] |
| protoErr | output | 1 | Sticky flag for both strobes being high together |

## Verification
The assertions check four things on every cycle: that the ports hold while no write is enabled or while the address phase is active, that at most one port byte changes per cycle, that the selected index stays put between address phases, and that the error flag never clears once set. Some behaviour can only be shown by the bench's scenarios. That covers the three-edge latency from bus to port, the mapping of each index to its byte lane, the dropping of the upper bus bits, the silence of out-of-range indices, and the retention of the address captured during a fault. The bench checks these against a cycle model that is fed the same random and directed strobe patterns.

// File: rtl/pex_pkg.sv
package pex_pkg;
  // Width of the port-number field; the decoder addresses up to eight ports.
  localparam int IDX_W = 3;

  typedef struct packed {
    logic             we;        // write the selected port this cycle
    logic             addrPhase; // synchronized address strobe is high
    logic [IDX_W-1:0] idx;       // effective port number
  } pexStrobe_t;
endpackage

// File: rtl/pex_ctrl.sv
module pex_ctrl
  import pex_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrLeIn,
  input  logic             dataLeIn,
  input  logic [IDX_W-1:0] busIdx,
  output pexStrobe_t       strb,
  output logic             errFlag
);
  localparam logic [IDX_W:0] PORT_LIM = (IDX_W+1)'(NUM_PORTS);

  logic [1:0]       addrSync, dataSync;
  logic             addrPrev;
  logic [IDX_W-1:0] shadowIdx, selIdx, effIdx;
  logic             addrHi, dataHi, addrFall;

  assign addrHi   = addrSync[1];
  assign dataHi   = dataSync[1];
  assign addrFall = addrPrev & ~addrHi;
  // On the falling edge the freshly frozen number is used at once.
  assign effIdx   = addrFall ? shadowIdx : selIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSync  <= '0;
      dataSync  <= '0;
      addrPrev  <= 1'b0;
      shadowIdx <= '0;
      selIdx    <= '0;
      errFlag   <= 1'b0;
    end else begin
      addrSync <= {addrSync[0], addrLeIn};
      dataSync <= {dataSync[0], dataLeIn};
      addrPrev <= addrHi;
      if (addrHi) shadowIdx <= busIdx;
      if (addrFall) selIdx <= shadowIdx;
      if (addrHi && dataHi) errFlag <= 1'b1;
    end
  end

  always_comb begin
    strb.addrPhase = addrHi;
    strb.idx       = effIdx;
    strb.we        = dataHi && !addrHi && ({1'b0, effIdx} < PORT_LIM);
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R7
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !addrHi ##1 !addrHi |-> $stable(strb.idx)); // R2
endmodule

// File: rtl/pex_datapath.sv
module pex_datapath
  import pex_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int NUM_PORTS = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [BUS_W-1:0]           busIn,
  input  pexStrobe_t                 strb,
  output logic [IDX_W-1:0]           busIdx,
  output logic [NUM_PORTS*BUS_W-1:0] portsFlat
);
  logic [BUS_W-1:0]     busP1, busP2;
  logic [BUS_W-1:0]     portsQ [NUM_PORTS];
  logic [BUS_W-1:0]     portsD [NUM_PORTS];
  logic [NUM_PORTS-1:0] portChg;

  // Bus delayed by the same two stages as the strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busP1 <= '0;
      busP2 <= '0;
    end else begin
      busP1 <= busIn;
      busP2 <= busP1;
    end
  end

  assign busIdx = busP2[IDX_W-1:0];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_comb begin
      portsD[g]  = (strb.we && strb.idx == IDX_W'(g)) ? busP2 : portsQ[g];
      portChg[g] = portsD[g] != portsQ[g];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) portsQ[g] <= '0;
      else       portsQ[g] <= portsD[g];
    end
    assign portsFlat[g*BUS_W +: BUS_W] = portsQ[g];
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.we |=> $stable(portsFlat)); // R5
  AST_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |=> $stable(portsFlat)); // R7
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portChg)); // R6
endmodule

// File: rtl/latched_port_expander.sv
module latched_port_expander
  import pex_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int NUM_PORTS = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [BUS_W-1:0]           busIn,
  input  logic                       addrLe,
  input  logic                       dataLe,
  output logic [NUM_PORTS*BUS_W-1:0] portsOut,
  output logic                       protoErr
);
  pexStrobe_t       strb;
  logic [IDX_W-1:0] busIdx;

  pex_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLeIn(addrLe), .dataLeIn(dataLe),
    .busIdx(busIdx), .strb(strb), .errFlag(protoErr)
  );

  pex_datapath #(.BUS_W(BUS_W), .NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .strb(strb),
    .busIdx(busIdx), .portsFlat(portsOut)
  );
endmodule

// File: tb/latched_port_expander_tb.sv
module latched_port_expander_tb;
  localparam int NP = 6;
  localparam int PW = NP * 8;

  logic clk = 0, rstN = 0, addrLe = 0, dataLe = 0;
  logic [7:0]    busIn = 0;
  logic [PW-1:0] portsOut;
  logic          protoErr;
  int nChk = 0, nFail = 0, cyc = 0;

  always #10 clk = ~clk;

  latched_port_expander #(.BUS_W(8), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .addrLe(addrLe), .dataLe(dataLe),
    .portsOut(portsOut), .protoErr(protoErr)
  );

  // Zero-latency protocol model; DUT lags it by two edges (synchronizers).
  logic [PW-1:0] mCur, h1, h2;
  logic          mErr, e1, e2;
  logic [2:0]    mIdx;
  always @(posedge clk) begin
    if (!rstN) begin
      mCur = '0; h1 = '0; h2 = '0; mErr = 0; e1 = 0; e2 = 0; mIdx = 0;
    end else begin
      h2 = h1; h1 = mCur; e2 = e1; e1 = mErr;
      if (addrLe) mIdx = busIn[2:0];
      if (addrLe && dataLe) mErr = 1;
      else if (dataLe && int'(mIdx) < NP) mCur[int'(mIdx)*8 +: 8] = busIn;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    chk("R4 R5 R6 cycle model ports", 64'(portsOut), 64'(h2));
    chk("R7 cycle model error", 64'(protoErr), 64'(e2));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  function automatic logic [7:0] pb(input int k);
    return portsOut[k*8 +: 8];
  endfunction

  task automatic drive(input logic a, input logic d, input logic [7:0] b, input int n);
    addrLe = a; dataLe = d; busIn = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic wrPort(input logic [7:0] idx, input logic [7:0] val);
    drive(0, 0, busIn, 3);
    drive(1, 0, idx, 3);
    drive(0, 0, idx, 3);
    drive(0, 0, val, 3);
    drive(0, 1, val, 5);
  endtask

  task automatic doReset();
    rstN = 0; addrLe = 0; dataLe = 0; busIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  logic [PW-1:0] snap;
  initial begin
    void'($urandom(32'd1234));
    doReset();
    chk("R1 ports after reset", 64'(portsOut), 64'd0);
    chk("R1 error after reset", 64'(protoErr), 64'd0);

    wrPort(2, 8'hA5);
    chk("R3 port 2 lane", 64'(pb(2)), 64'hA5);
    chk("R6 other ports untouched", 64'(portsOut), 64'(48'hA5 << 16));

    // R4 latency: bus change at this negedge, visible after the third edge
    busIn = 8'h3C;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 not yet visible", 64'(pb(2)), 64'hA5);
    @(negedge clk);
    chk("R4 follows bus", 64'(pb(2)), 64'h3C);

    drive(0, 0, 8'h3C, 3);
    drive(0, 0, 8'hFF, 6);
    chk("R5 hold with data strobe low", 64'(portsOut), 64'(48'h3C << 16));

    drive(1, 0, 8'h01, 3);
    drive(0, 0, 8'h01, 3);
    drive(0, 0, 8'h05, 3);
    drive(0, 0, 8'h77, 2);
    drive(0, 1, 8'h77, 5);
    chk("R2 frozen index port 1", 64'(pb(1)), 64'h77);
    chk("R2 port 5 untouched", 64'(pb(5)), 64'h00);

    wrPort(8'hFB, 8'h9E);
    chk("R8 upper bits ignored", 64'(pb(3)), 64'h9E);

    drive(0, 0, 8'h00, 3);
    snap = portsOut;
    wrPort(8'h07, 8'h11);
    wrPort(8'h06, 8'h22);
    chk("R9 out of range writes nothing", 64'(portsOut), 64'(snap));

    drive(0, 0, 8'h00, 3);
    snap = portsOut;
    drive(1, 1, 8'h04, 5);
    chk("R7 error raised", 64'(protoErr), 64'd1);
    chk("R7 no write on violation", 64'(portsOut), 64'(snap));
    drive(1, 0, 8'h04, 3);
    drive(0, 0, 8'h04, 3);
    drive(0, 0, 8'h6B, 2);
    drive(0, 1, 8'h6B, 5);
    chk("R7 address kept from violation", 64'(pb(4)), 64'h6B);
    chk("R7 error sticky", 64'(protoErr), 64'd1);

    doReset();
    chk("R1 reset clears error", 64'(protoErr), 64'd0);
    for (int i = 0; i < 3000; i++) begin
      addrLe = ($urandom % 8) == 0;
      dataLe = ($urandom % 3) == 0;
      if (addrLe && dataLe && ($urandom % 6) != 0) dataLe = 0;
      busIn  = 8'($urandom);
      @(negedge clk);
    end
    drive(0, 0, 8'h00, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule